// File: doc/BRIEF.md
# Platform Interrupt Router

This block gathers level-sensitive interrupt lines from a configurable set of sources and delivers them to a configurable set of hart contexts. Each source has a programmable priority. Each context has its own enable bit per source, its own threshold and one interrupt output. Software reaches all of this through a single-cycle read/write strobe interface with a registered response.

A hart takes work by reading its context's claim register. The read returns the identifier of the best eligible source and retires that source's pending state in the same access. The hart finishes the work by writing the same identifier back to that register. A source's gateway stays quiet between the claim and the completion. Identifier 0 is reserved to mean "nothing to take".

Address map (byte addresses):
- Priority word for source n: 4·n.
- Enable words: base 0x2000, 0x80 per context.
- Context windows: base 0x200000, 0x1000 per context. The threshold is at window offset 0 and the claim/complete register is at offset 4.

Top module: `irq_router_core`

## Requirements
- R1: Every request strobe produces `rsp_valid` exactly one cycle later. Writes, and reads of unmapped addresses (for example 0x1000 or window offset 8), return 0 on `rsp_rdata`.
- R2: The priority of source n reads and writes at byte address 4·n and keeps only the low PRIO_W bits of the written data. The entry for source 0 always reads 0 and ignores writes.
- R3: The enable bit of source n for context c is bit (n mod 32) of the word at 0x2000 + 0x80·c + 4·(n/32). The bit for source 0 always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000·c. `ctx_irq[c]` goes high two cycles after a line rises, and only if some pending source enabled for c has a priority strictly greater than that threshold. It goes low once no such source remains.
- R5: A read of the claim register at 0x200004 + 0x1000·c returns the eligible source with the highest priority, taking the lowest ID among equal priorities. The decision uses the state present at the access edge, and the read clears that source's pending bit.
- R6: A claim read with no eligible source returns 0 and changes no state.
- R7: A claimed source does not become pending again, even with its line held high, until its ID is written to a claim register. After that write, a line that is still high pends again on the next cycle.
- R8: A completion write whose ID is not enabled for the writing context has no effect.
- R9: A source whose priority is 0 never raises any `ctx_irq` and is never returned by a claim read.
- R10: After reset, all priorities, enables, thresholds and pending bits are 0 and every `ctx_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Level interrupt lines; bit 0 is unused |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| ctx_irq | output | NUM_CTX | Registered interrupt request per context |

## Verification
A claim read can land on the same clock edge at which a gateway samples a newly raised, higher-priority line. The bench provokes this by driving the claim request and the new line on the same falling edge.

Judged by R5, the claim must return the source that was already pending. The newcomer must become pending at that edge and be returned by the next claim. Completion followed by immediate re-pending of a still-high line is checked the same way, across consecutive cycles.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } region_e;

  localparam logic [31:0] PRIO_BASE = 32'h0000_0000;
  localparam logic [31:0] PRIO_END  = 32'h0000_1000;
  localparam logic [31:0] EN_BASE   = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE = 32'h0000_0080;
  localparam logic [31:0] CW_BASE   = 32'h0020_0000;
  localparam logic [31:0] CW_STRIDE = 32'h0000_1000;
endpackage

// File: rtl/irqr_gateway.sv
module irqr_gateway #(
  parameter bit RESERVED = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic claim_i,
  input  logic cmpl_i,
  output logic pend_o,
  output logic busy_o
);
  generate
    if (RESERVED) begin : g_tied
      assign pend_o = 1'b0;
      assign busy_o = 1'b0;
    end else begin : g_live
      logic pend_q, busy_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q <= 1'b0;
          busy_q <= 1'b0;
        end else if (claim_i) begin
          pend_q <= 1'b0;
          busy_q <= 1'b1;
        end else begin
          if (cmpl_i) busy_q <= 1'b0;
          if (line_i && !pend_q && !busy_q) pend_q <= 1'b1;
        end
      end
      assign pend_o = pend_q;
      assign busy_o = busy_q;

      // R5
      claim_clears_chk: assert property (@(posedge clk) disable iff (rst)
        claim_i |=> (!pend_o && busy_o));
      // R7
      hold_until_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !cmpl_i) |=> !pend_o);
    end
  endgenerate
endmodule

// File: rtl/irqr_arbiter.sv
module irqr_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [ID_W-1:0]           best_id_o,
  output logic [PRIO_W-1:0]         best_prio_o,
  output logic                      ok_o
);
  always_comb begin
    best_id_o   = '0;
    best_prio_o = '0;
    // ascending scan with strict compare: lowest ID wins a tie, priority 0 never wins
    for (int s = 1; s < NUM_SRC; s++) begin
      if (pend_i[s] && en_i[s] && (prio_i[s*PRIO_W +: PRIO_W] > best_prio_o)) begin
        best_id_o   = ID_W'(s);
        best_prio_o = prio_i[s*PRIO_W +: PRIO_W];
      end
    end
  end

  assign ok_o = best_prio_o > thr_i;
endmodule

// File: rtl/irq_router_core.sv
module irq_router_core
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CTX-1:0] ctx_irq
);
  localparam int ID_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int EN_WORDS = (NUM_SRC + 31) / 32;

  // ---------------- state ----------------
  logic [PRIO_W-1:0]         prio_q [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        en_q   [NUM_CTX];
  logic [NUM_SRC-1:0]        en_d   [NUM_CTX];
  logic [PRIO_W-1:0]         thr_q  [NUM_CTX];
  logic [NUM_SRC-1:0]        pend_vec, busy_vec, claim_vec, cmpl_vec;

  logic [ID_W-1:0]   win_id   [NUM_CTX];
  logic [PRIO_W-1:0] win_prio [NUM_CTX];
  logic [NUM_CTX-1:0] win_ok;

  // ---------------- decode ----------------
  region_e     dec_rg;
  logic [31:0] a32, off, dec_c, dec_idx;

  always_comb begin
    a32     = 32'(req_addr);
    dec_rg  = RG_NONE;
    dec_c   = '0;
    dec_idx = '0;
    off     = '0;
    if (a32 < PRIO_END) begin
      dec_idx = a32 >> 2;
      if (a32[1:0] == 2'b00 && dec_idx < 32'(NUM_SRC)) dec_rg = RG_PRIO;
    end else if (a32 >= EN_BASE && a32 < EN_BASE + EN_STRIDE * 32'(NUM_CTX)) begin
      off     = a32 - EN_BASE;
      dec_c   = off >> 7;
      dec_idx = 32'(off[6:2]);
      if (off[1:0] == 2'b00 && dec_idx < 32'(EN_WORDS)) dec_rg = RG_EN;
    end else if (a32 >= CW_BASE && a32 < CW_BASE + CW_STRIDE * 32'(NUM_CTX)) begin
      off   = a32 - CW_BASE;
      dec_c = off >> 12;
      if (off[11:0] == 12'h000) dec_rg = RG_THR;
      else if (off[11:0] == 12'h004) dec_rg = RG_CLAIM;
    end
  end

  logic rd_go, wr_go;
  assign rd_go = req_valid && !req_write;
  assign wr_go = req_valid &&  req_write;

  // ---------------- per-source gateways ----------------
  genvar gs;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
      irqr_gateway #(.RESERVED(gs == 0)) u_gw (
        .clk    (clk),
        .rst    (rst),
        .line_i (src_irq[gs]),
        .claim_i(claim_vec[gs]),
        .cmpl_i (cmpl_vec[gs]),
        .pend_o (pend_vec[gs]),
        .busy_o (busy_vec[gs])
      );
      assign prio_flat[gs*PRIO_W +: PRIO_W] = prio_q[gs];
    end
  endgenerate

  // ---------------- per-context arbiters ----------------
  genvar gc;
  generate
    for (gc = 0; gc < NUM_CTX; gc++) begin : g_ctx
      irqr_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .pend_i     (pend_vec),
        .en_i       (en_q[gc]),
        .prio_i     (prio_flat),
        .thr_i      (thr_q[gc]),
        .best_id_o  (win_id[gc]),
        .best_prio_o(win_prio[gc]),
        .ok_o       (win_ok[gc])
      );

      // R4
      irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctx_irq[gc]) |-> $past(|(pend_vec & en_q[gc])));
    end
  endgenerate

  // ---------------- claim / complete ----------------
  logic            sel_ok;
  logic [ID_W-1:0] sel_id;
  logic            do_claim;

  always_comb begin
    sel_ok = 1'b0;
    sel_id = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (32'(c) == dec_c) begin
        sel_ok = win_ok[c];
        sel_id = win_id[c];
      end
    end
  end

  assign do_claim = rd_go && dec_rg == RG_CLAIM && sel_ok;

  always_comb begin
    claim_vec = '0;
    cmpl_vec  = '0;
    for (int s = 1; s < NUM_SRC; s++) begin
      if (do_claim && sel_id == ID_W'(s)) claim_vec[s] = 1'b1;
      for (int c = 0; c < NUM_CTX; c++) begin
        if (wr_go && dec_rg == RG_CLAIM && 32'(c) == dec_c &&
            req_wdata == 32'(s) && en_q[c][s])
          cmpl_vec[s] = 1'b1;
      end
    end
  end

  // ---------------- register writes ----------------
  always_comb begin
    for (int c = 0; c < NUM_CTX; c++) begin
      en_d[c] = en_q[c];
      for (int s = 1; s < NUM_SRC; s++) begin
        if (wr_go && dec_rg == RG_EN && 32'(c) == dec_c && 32'(s / 32) == dec_idx)
          en_d[c][s] = req_wdata[s % 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else begin
      for (int s = 1; s < NUM_SRC; s++) begin
        if (wr_go && dec_rg == RG_PRIO && 32'(s) == dec_idx)
          prio_q[s] <= req_wdata[PRIO_W-1:0];
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        en_q[c] <= en_d[c];
        if (wr_go && dec_rg == RG_THR && 32'(c) == dec_c)
          thr_q[c] <= req_wdata[PRIO_W-1:0];
      end
    end
  end

  // ---------------- read mux and registered outputs ----------------
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (rd_go) begin
      unique case (dec_rg)
        RG_PRIO: begin
          for (int s = 1; s < NUM_SRC; s++)
            if (32'(s) == dec_idx) rd_mux = 32'(prio_q[s]);
        end
        RG_EN: begin
          for (int c = 0; c < NUM_CTX; c++)
            for (int s = 1; s < NUM_SRC; s++)
              if (32'(c) == dec_c && 32'(s / 32) == dec_idx)
                rd_mux[s % 32] = en_q[c][s];
        end
        RG_THR: begin
          for (int c = 0; c < NUM_CTX; c++)
            if (32'(c) == dec_c) rd_mux = 32'(thr_q[c]);
        end
        RG_CLAIM: rd_mux = sel_ok ? 32'(sel_id) : 32'd0;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ctx_irq   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_mux;
      ctx_irq   <= win_ok;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/irq_router_core_tb.sv
module irq_router_core_tb;
  localparam int NS = 32;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_irq = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [23:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] ctx_irq;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  irq_router_core #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3), .ADDR_W(24)) u_dut (
    .clk(clk), .rst(rst), .src_irq(src_irq),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ctx_irq(ctx_irq)
  );

  function automatic logic [23:0] a_prio(int n);
    return 24'(4 * n);
  endfunction
  function automatic logic [23:0] a_en(int c, int w);
    return 24'(32'h2000 + 32'h80 * c + 4 * w);
  endfunction
  function automatic logic [23:0] a_thr(int c);
    return 24'(32'h200000 + 32'h1000 * c);
  endfunction
  function automatic logic [23:0] a_clm(int c);
    return 24'(32'h200004 + 32'h1000 * c);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R1 unexpected response", rsp_rdata, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_rdata == e.data, e.tag, rsp_rdata, e.data);
      end
    end
  end

  task automatic bus(input bit wr, input logic [23:0] addr, input logic [31:0] wd,
                     input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = wd;
    sb_q.push_back('{data: exp, tag: tag});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [23:0] addr, input logic [31:0] wd);
    bus(1'b1, addr, wd, 32'h0, "R1 write response");
  endtask
  task automatic rd(input logic [23:0] addr, input logic [31:0] exp, input string tag);
    bus(1'b0, addr, 32'h0, exp, tag);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctx_irq == 2'b00, "R10 irq low after reset", 32'(ctx_irq), 32'h0);
    rd(a_prio(5), 32'h0, "R10 priority reset");
    rd(a_thr(1), 32'h0, "R10 threshold reset");
    rd(a_en(0, 0), 32'h0, "R10 enable reset");
    rd(a_clm(0), 32'h0, "R6 empty claim");

    // R2 priority access
    wr(a_prio(0), 32'h7);
    rd(a_prio(0), 32'h0, "R2 source 0 priority fixed");
    wr(a_prio(5), 32'h3);
    rd(a_prio(5), 32'h3, "R2 priority readback");
    wr(a_prio(7), 32'hB);
    rd(a_prio(7), 32'h3, "R2 priority width mask");
    wr(a_prio(9), 32'h2);

    // R1 unmapped
    rd(24'h001000, 32'h0, "R1 unmapped read");
    rd(24'h200008, 32'h0, "R1 unmapped window offset");

    // R3 enables
    wr(a_en(0, 0), 32'h0000_02A1);
    rd(a_en(0, 0), 32'h0000_02A0, "R3 enable word ctx0");
    wr(a_en(1, 0), 32'h0000_0200);
    rd(a_en(1, 0), 32'h0000_0200, "R3 enable word ctx1");

    // R4 delivery and R5 tie on priority
    src_irq[5] = 1'b1;
    src_irq[7] = 1'b1;
    idle(3);
    chk(ctx_irq == 2'b01, "R4 irq asserted ctx0 only", 32'(ctx_irq), 32'h1);
    rd(a_clm(0), 32'd5, "R5 lowest ID wins tie");
    rd(a_clm(0), 32'd7, "R5 next claim");
    rd(a_clm(0), 32'd0, "R6 nothing left");
    idle(3);
    chk(ctx_irq == 2'b00, "R4 irq drops after claims", 32'(ctx_irq), 32'h0);

    // R7 gating until completion
    rd(a_clm(0), 32'd0, "R7 no re-pend while claimed");
    wr(a_clm(0), 32'd5);
    idle(2);
    rd(a_clm(0), 32'd5, "R7 re-pend after completion");

    // R8 foreign completion ignored
    wr(a_clm(1), 32'd7);
    idle(2);
    rd(a_clm(0), 32'd0, "R8 foreign completion ignored");
    wr(a_clm(0), 32'd7);
    idle(2);
    rd(a_clm(0), 32'd7, "R8 own completion accepted");
    src_irq[5] = 1'b0;
    src_irq[7] = 1'b0;
    wr(a_clm(0), 32'd5);
    wr(a_clm(0), 32'd7);
    idle(2);
    rd(a_clm(0), 32'd0, "R7 low line stays idle");

    // R4 strict threshold
    src_irq[9] = 1'b1;
    wr(a_thr(1), 32'd2);
    rd(a_thr(1), 32'd2, "R4 threshold readback");
    idle(3);
    chk(ctx_irq[1] == 1'b0, "R4 equal to threshold blocked", 32'(ctx_irq[1]), 32'h0);
    wr(a_thr(1), 32'd1);
    idle(3);
    chk(ctx_irq[1] == 1'b1, "R4 above threshold delivered", 32'(ctx_irq[1]), 32'h1);

    // R9 priority zero
    wr(a_prio(9), 32'd0);
    idle(3);
    chk(ctx_irq == 2'b00, "R9 zero priority silent", 32'(ctx_irq), 32'h0);
    rd(a_clm(1), 32'd0, "R9 zero priority not claimable");

    // R5 higher priority beats lower ID
    wr(a_prio(9), 32'd6);
    src_irq[7] = 1'b1;
    idle(3);
    rd(a_clm(0), 32'd9, "R5 higher priority first");
    rd(a_clm(0), 32'd7, "R5 lower priority second");

    // same-edge: claim while a higher-priority line rises
    src_irq[7] = 1'b0;
    src_irq[9] = 1'b0;
    wr(a_clm(0), 32'd9);
    wr(a_clm(0), 32'd7);
    src_irq[5] = 1'b1;
    idle(3);
    @(negedge clk);
    src_irq[9] = 1'b1;
    req_valid  = 1'b1;
    req_write  = 1'b0;
    req_addr   = a_clm(0);
    sb_q.push_back('{data: 32'd5, tag: "R5 claim uses state at access edge"});
    @(negedge clk);
    req_valid = 1'b0;
    rd(a_clm(0), 32'd9, "R5 newcomer claimed next");

    idle(3);
    chk(sb_q.size() == 0, "R1 all responses seen", 32'(sb_q.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule